// File: doc/BRIEF.md
# End-Pointer DMA Channel Engine

This block is one channel of a memory-to-peripheral DMA engine. Software places a three-word channel descriptor in a table in memory: the last source address, the last destination address and a control word. Both addresses are inclusive end points. The engine works out every element address by stepping back from those end points by the number of elements still to move. For a peripheral whose address does not increment, the destination stays on the end pointer, which is the peripheral's data register.

A peripheral transmit FIFO asks for data with a single request or a burst request. For each request the engine reads the descriptor again and moves one element, or a burst of up to 2^k elements. It then writes the updated control word back. When the last element has moved, the engine clears the mode field in that word, drops its own enable bit and, if allowed, pulses a completion interrupt.

Software sets the channel's attributes through pairs of write-one-to-set and write-one-to-clear registers. The attributes are enable, priority, alternate descriptor select, burst-only mode, request mask and interrupt enable.

Top module: `epdma_engine`

## Requirements
- R1: After reset every attribute reads 0, no memory access is made and `done_irq` is low.
- R2: Configuration index 2a sets and index 2a+1 clears attribute a when bit CHAN (default 7) of the written data is 1. The attribute order is: 0 enable, 1 priority, 2 alternate, 3 burst-only, 4 mask, 5 interrupt enable. Written data without bit CHAN leaves the attribute unchanged. The new value is visible on the next cycle, at bit CHAN, when reading either index of the pair. Index 12 holds the table base address.
- R3: The descriptor is read from base + CHAN×16 when alternate is 0, or from base + NUM_CH×16 + CHAN×16 when alternate is 1. The words are read in this order: source end (+0), destination end (+4), control word (+8).
- R4: The control word fields are: mode [2:0] (0 means stopped), count-1 [13:4], burst exponent k [17:14], source step [25:24] and destination step [31:30]. The step codes are 0 byte, 1 halfword, 2 word and 3 none. The element address is end − (remaining−1)×step. With step code 3 the address is the end pointer itself. Elements are one byte wide.
- R5: A burst request moves min(2^k, remaining) elements. A single request moves exactly one element. When both requests are present, the burst request wins.
- R6: Requests are ignored while enable is 0 or mask is 1. While burst-only is 1, single requests are ignored.
- R7: After each burst the control word is written back to +8. The count field holds remaining−1 and the mode field is unchanged. Once no elements remain, the mode field and the count field are both written as 0.
- R8: At completion the enable bit clears. `done_irq` pulses high for exactly one cycle, but only if interrupt enable is 1.
- R9: A control word that is fetched with mode 0 moves no element, clears the enable bit and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, driven combinationally from the index |
| req_single | input | 1 | Peripheral single-element request |
| req_burst | input | 1 | Peripheral burst request |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory access is a write |
| mem_size | output | 2 | Access size: 0 byte, 2 word |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the read |
| done_irq | output | 1 | Completion interrupt pulse |

## Verification
Some rules are checked by assertions on every cycle. The interrupt must be a single-cycle pulse. The enable bit must already be clear when the interrupt is seen. A set write to enable must show on the next cycle. A masked channel must stay idle. Every destination write under step code 3 must land on the destination end pointer. Other behaviour can only be shown by the bench's scenarios, which compare the bytes delivered to the FIFO against expected values. These scenarios cover the element order and address stepping for each step code, the length of the first burst against the cap, the written-back control words, the choice of alternate descriptor, and the paths where requests are ignored.

// File: rtl/epdma_pkg.sv
package epdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_F0, ST_F1, ST_F2, ST_F3, ST_RD, ST_WR, ST_WB
  } st_e;

  // attribute slots, set index = 2*slot, clear index = 2*slot+1
  localparam int NATTR    = 6;
  localparam int A_EN     = 0;
  localparam int A_PRIO   = 1;
  localparam int A_ALT    = 2;
  localparam int A_UB     = 3;
  localparam int A_MASK   = 4;
  localparam int A_IE     = 5;
  localparam int REG_BASE = 2 * NATTR;

  // control word layout
  localparam int MODE_LSB = 0;
  localparam int MODE_W   = 3;
  localparam int CNT_LSB  = 4;
  localparam int ARB_LSB  = 14;
  localparam int ARB_W    = 4;
  localparam int SINC_LSB = 24;
  localparam int DINC_LSB = 30;

  localparam logic [1:0] INC_NONE = 2'd3;
  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam int         STRIDE   = 16;

endpackage

// File: rtl/epdma_attr.sv
module epdma_attr #(
  parameter int NATTR = 6,
  parameter int DW    = 32,
  parameter int CHAN  = 7,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [NATTR-1:0] hw_clr,
  output logic [NATTR-1:0] attr_q
);

  logic [NATTR-1:0] attr_d;

  for (genvar g = 0; g < NATTR; g++) begin : g_attr
    localparam logic [IDX_W-1:0] SET_IDX = IDX_W'(2 * g);
    localparam logic [IDX_W-1:0] CLR_IDX = IDX_W'(2 * g + 1);
    logic hit_set, hit_clr;

    always_comb begin
      hit_set = wr_en && (wr_idx == SET_IDX) && wr_data[CHAN];
      hit_clr = wr_en && (wr_idx == CLR_IDX) && wr_data[CHAN];
      if (hw_clr[g])    attr_d[g] = 1'b0;
      else if (hit_set) attr_d[g] = 1'b1;
      else if (hit_clr) attr_d[g] = 1'b0;
      else              attr_d[g] = attr_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) attr_q[g] <= 1'b0;
      else        attr_q[g] <= attr_d[g];
    end
  end

endmodule

// File: rtl/epdma_agen.sv
module epdma_agen #(
  parameter int AW = 32,
  parameter int CW = 11
) (
  input  logic [AW-1:0] end_ptr,
  input  logic [CW-1:0] remain,
  input  logic [1:0]    step,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] span;

  always_comb begin
    span = AW'(remain - CW'(1)) << step;
    if (step == epdma_pkg::INC_NONE) addr = end_ptr;
    else                             addr = end_ptr - span;
  end

endmodule

// File: rtl/epdma_engine.sv
module epdma_engine
  import epdma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int CNT_W  = 10,
  parameter int CHAN   = 7,
  parameter int NUM_CH = 32,
  parameter int CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              req_single,
  input  logic              req_burst,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              done_irq
);

  localparam int          REM_W   = CNT_W + 1;
  localparam logic [AW-1:0] PRI_OFF = AW'(CHAN * STRIDE);
  localparam logic [AW-1:0] ALT_OFF = AW'(NUM_CH * STRIDE);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  st_e              st_q, st_d;
  logic [AW-1:0]    src_q, src_d, dst_q, dst_d, base_q, base_d;
  logic [DW-1:0]    ctrl_q, ctrl_d;
  logic [REM_W-1:0] rem_q, rem_d, len_q, len_d;
  logic             burst_q, burst_d, irq_q, irq_d;
  logic [NATTR-1:0] attr_q, hw_clr;

  logic [AW-1:0]    ctl_addr, src_addr, dst_addr;
  logic [REM_W-1:0] fetch_rem, fetch_len, cap;
  logic [ARB_W-1:0] arb;
  logic [DW-1:0]    wb_word;
  logic             recog;

  epdma_attr #(.NATTR(NATTR), .DW(DW), .CHAN(CHAN), .IDX_W(CFG_AW)) u_attr (
    .clk(clk), .rst_n(rst_n_i), .wr_en(cfg_we), .wr_idx(cfg_addr),
    .wr_data(cfg_wdata), .hw_clr(hw_clr), .attr_q(attr_q)
  );

  epdma_agen #(.AW(AW), .CW(REM_W)) u_src_agen (
    .end_ptr(src_q), .remain(rem_q), .step(ctrl_q[SINC_LSB +: 2]), .addr(src_addr)
  );

  epdma_agen #(.AW(AW), .CW(REM_W)) u_dst_agen (
    .end_ptr(dst_q), .remain(rem_q), .step(ctrl_q[DINC_LSB +: 2]), .addr(dst_addr)
  );

  // configuration read and base register
  always_comb begin
    cfg_rdata = '0;
    base_d    = base_q;
    if (cfg_addr == CFG_AW'(REG_BASE)) cfg_rdata = DW'(base_q);
    else if (int'(cfg_addr) < REG_BASE) cfg_rdata[CHAN] = attr_q[cfg_addr[CFG_AW-1:1]];
    if (cfg_we && cfg_addr == CFG_AW'(REG_BASE)) base_d = AW'(cfg_wdata);
  end

  assign ctl_addr = base_q + PRI_OFF + (attr_q[A_ALT] ? ALT_OFF : '0);
  assign recog    = attr_q[A_EN] && !attr_q[A_MASK] &&
                    (req_burst || (req_single && !attr_q[A_UB]));

  // element count and burst length from a freshly fetched control word
  always_comb begin
    fetch_rem = REM_W'(mem_rdata[CNT_LSB +: CNT_W]) + REM_W'(1);
    arb       = mem_rdata[ARB_LSB +: ARB_W];
    cap       = REM_W'(1) << arb;
    if (!burst_q)                 fetch_len = REM_W'(1);
    else if (int'(arb) >= REM_W)  fetch_len = fetch_rem;
    else if (cap < fetch_rem)     fetch_len = cap;
    else                          fetch_len = fetch_rem;
  end

  always_comb begin
    wb_word = ctrl_q;
    if (rem_q == '0) begin
      wb_word[MODE_LSB +: MODE_W] = '0;
      wb_word[CNT_LSB +: CNT_W]   = '0;
    end else begin
      wb_word[CNT_LSB +: CNT_W]   = CNT_W'(rem_q - REM_W'(1));
    end
  end

  // next state and memory port
  always_comb begin
    st_d = st_q; src_d = src_q; dst_d = dst_q; ctrl_d = ctrl_q;
    rem_d = rem_q; len_d = len_q; burst_d = burst_q;
    hw_clr = '0; irq_d = 1'b0;
    mem_req = 1'b0; mem_we = 1'b0; mem_size = SZ_WORD;
    mem_addr = ctl_addr; mem_wdata = '0;
    unique case (st_q)
      ST_IDLE: if (recog) begin
        burst_d = req_burst;
        st_d    = ST_F0;
      end
      ST_F0: begin
        mem_req = 1'b1;
        st_d    = ST_F1;
      end
      ST_F1: begin
        src_d    = AW'(mem_rdata);
        mem_req  = 1'b1;
        mem_addr = ctl_addr + AW'(4);
        st_d     = ST_F2;
      end
      ST_F2: begin
        dst_d    = AW'(mem_rdata);
        mem_req  = 1'b1;
        mem_addr = ctl_addr + AW'(8);
        st_d     = ST_F3;
      end
      ST_F3: begin
        ctrl_d = mem_rdata;
        rem_d  = fetch_rem;
        len_d  = fetch_len;
        if (mem_rdata[MODE_LSB +: MODE_W] == '0) begin
          hw_clr[A_EN] = 1'b1;
          st_d         = ST_IDLE;
        end else begin
          st_d = ST_RD;
        end
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_size = SZ_BYTE;
        mem_addr = src_addr;
        st_d     = ST_WR;
      end
      ST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_size  = SZ_BYTE;
        mem_addr  = dst_addr;
        mem_wdata = DW'(mem_rdata[7:0]);
        rem_d     = rem_q - REM_W'(1);
        len_d     = len_q - REM_W'(1);
        st_d      = (len_q == REM_W'(1)) ? ST_WB : ST_RD;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ctl_addr + AW'(8);
        mem_wdata = wb_word;
        st_d      = ST_IDLE;
        if (rem_q == '0) begin
          hw_clr[A_EN] = 1'b1;
          irq_d        = attr_q[A_IE];
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q <= ST_IDLE; src_q <= '0; dst_q <= '0; ctrl_q <= '0; base_q <= '0;
      rem_q <= '0; len_q <= '0; burst_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      st_q <= st_d; src_q <= src_d; dst_q <= dst_d; ctrl_q <= ctrl_d; base_q <= base_d;
      rem_q <= rem_d; len_q <= len_d; burst_q <= burst_d; irq_q <= irq_d;
    end
  end

  assign done_irq = irq_q;

endmodule

// File: rtl/epdma_chk.sv
module epdma_chk
  import epdma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int CHAN   = 7,
  parameter int CFG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_irq,
  input logic              en_bit,
  input logic              mask_bit,
  input st_e               st,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [AW-1:0]     dst_end,
  input logic [1:0]        dst_step,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [DW-1:0]     cfg_wdata
);

  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  a_r8_en_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !en_bit);

  // R2: a set write to enable is visible on the next cycle
  a_r2_set_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_AW'(2 * A_EN) && cfg_wdata[CHAN] &&
     st != ST_WB && st != ST_F3) |=> en_bit);

  a_r6_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && mask_bit) |=> st == ST_IDLE);

  a_r4_fixed_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR && dst_step == INC_NONE) |-> (mem_we && mem_addr == dst_end));

endmodule

bind epdma_engine epdma_chk #(.AW(AW), .DW(DW), .CHAN(CHAN), .CFG_AW(CFG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .done_irq(done_irq),
  .en_bit(attr_q[epdma_pkg::A_EN]), .mask_bit(attr_q[epdma_pkg::A_MASK]),
  .st(st_q), .mem_we(mem_we), .mem_addr(mem_addr), .dst_end(dst_q),
  .dst_step(ctrl_q[epdma_pkg::DINC_LSB +: 2]),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
);

// File: tb/sim_epdma_engine.sv
module sim_epdma_engine;

  localparam int FIFO  = 'h3F0;
  localparam int BASE  = 'h800;
  localparam int PRI   = BASE + 'h70;
  localparam int ALT   = BASE + 'h200 + 'h70;
  localparam int NV    = 6;
  localparam int VB[NV] = '{'h100, 'h200, 'h240, 'h280, 'h2C0, 'h300};
  localparam int VN[NV] = '{64, 3, 5, 6, 4, 1};
  localparam int VA[NV] = '{2, 3, 0, 1, 4, 2};
  localparam int VS[NV] = '{0, 0, 0, 1, 2, 0};
  localparam int VF[NV] = '{4, 3, 1, 2, 4, 1};

  logic        clk, rst_n, cfg_we, req_single, req_burst;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, done_irq;
  logic [1:0]  mem_size;

  logic [7:0]  mem [0:4095];
  logic [7:0]  fifo_buf [0:127];
  int          fifo_cnt, req_cnt, first_len;
  logic        wb_seen, irq_seen, mon_clr, tb_we;
  logic [11:0] tb_addr;
  logic [31:0] tb_data;
  int          tests, fails;

  epdma_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_single(req_single),
    .req_burst(req_burst), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done_irq(done_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] pat(int a);
    return 8'(a) ^ 8'hA5 ^ {4'h0, 4'(a >> 8)};
  endfunction

  function automatic logic [31:0] rd32(int a);
    return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
  endfunction

  function automatic logic [31:0] cw(int mode, int n, int arb, int si, int di);
    return 32'(mode) | (32'(n - 1) << 4) | (32'(arb) << 14) | (32'(si) << 24) | (32'(di) << 30);
  endfunction

  // memory and peripheral model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
      mem_rdata <= '0;
    end else begin
      if (tb_we) for (int b = 0; b < 4; b++) mem[tb_addr + 12'(b)] <= tb_data[8*b +: 8];
      if (mem_req && !mem_we)
        mem_rdata <= (mem_size == 2'd2) ? rd32(int'(mem_addr[11:0])) : {24'h0, mem[mem_addr[11:0]]};
      if (mem_req && mem_we) begin
        if (mem_size == 2'd0 && int'(mem_addr) == FIFO) begin
          fifo_buf[fifo_cnt[6:0]] <= mem_wdata[7:0];
          fifo_cnt <= fifo_cnt + 1;
        end else if (mem_size == 2'd0) begin
          mem[mem_addr[11:0]] <= mem_wdata[7:0];
        end else begin
          for (int b = 0; b < 4; b++) mem[mem_addr[11:0] + 12'(b)] <= mem_wdata[8*b +: 8];
          if (!wb_seen) first_len <= fifo_cnt;
          wb_seen <= 1'b1;
        end
      end
    end
    if (mem_req) req_cnt <= req_cnt + 1;
    if (done_irq) irq_seen <= 1'b1;
    if (mon_clr || !rst_n) begin
      fifo_cnt <= 0; req_cnt <= 0; first_len <= 0; wb_seen <= 1'b0; irq_seen <= 1'b0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int idx, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 4'(idx); cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input int idx, output logic [31:0] v);
    cfg_addr = 4'(idx);
    #1 v = cfg_rdata;
  endtask

  task automatic mem_w32(input int a, input logic [31:0] d);
    tb_we = 1'b1; tb_addr = 12'(a); tb_data = d;
    tick(1);
    tb_we = 1'b0;
  endtask

  task automatic clr_mon();
    mon_clr = 1'b1; tick(1); mon_clr = 1'b0;
  endtask

  task automatic put_desc(input int at, input int src_end, input logic [31:0] ctl);
    mem_w32(at, 32'(src_end));
    mem_w32(at + 4, FIFO);
    mem_w32(at + 8, ctl);
  endtask

  task automatic wait_irq(input int lim, input string tag);
    int k;
    k = 0;
    while (!irq_seen && k < lim) begin tick(1); k++; end
    check(irq_seen, tag, int'(irq_seen), 1);
  endtask

  // watchdog
  initial begin
    tick(150000);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

  initial begin
    logic [31:0] v, acc;
    int bad, step;
    tests = 0; fails = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_single = 1'b0; req_burst = 1'b0; tb_we = 1'b0; tb_addr = '0; tb_data = '0; mon_clr = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state
    acc = '0;
    for (int i = 0; i < 12; i++) begin cfg_rd(i, v); acc = acc | v; end
    check(acc == 0, "R1 attributes after reset", int'(acc), 0);
    check(!mem_req && !done_irq, "R1 idle outputs", int'({mem_req, done_irq}), 0);

    // R6: disabled channel ignores requests
    clr_mon();
    req_burst = 1'b1; tick(12); req_burst = 1'b0;
    check(req_cnt == 0, "R6 disabled ignores request", req_cnt, 0);

    // R2: set/clear pair on priority
    cfg_wr(2, 32'h80);
    cfg_rd(2, v); check(v == 32'h80, "R2 set read via set index", int'(v), 'h80);
    cfg_rd(3, v); check(v == 32'h80, "R2 set read via clear index", int'(v), 'h80);
    cfg_wr(3, 32'hFFFF_FF7F);
    cfg_rd(2, v); check(v == 32'h80, "R2 clear without channel bit ignored", int'(v), 'h80);
    cfg_wr(3, 32'h80);
    cfg_rd(2, v); check(v == 0, "R2 clear", int'(v), 0);

    cfg_wr(12, BASE);
    cfg_wr(10, 32'h80);

    // table-driven transfers: R4, R5, R7, R8
    for (int t = 0; t < NV; t++) begin
      step = 1 << VS[t];
      clr_mon();
      put_desc(PRI, VB[t] + (VN[t] - 1) * step, cw(1, VN[t], VA[t], VS[t], 3));
      cfg_wr(0, 32'h80);
      req_burst = 1'b1;
      wait_irq(4000, "R8 interrupt raised");
      req_burst = 1'b0;
      tick(2);
      check(fifo_cnt == VN[t], "R5 element count", fifo_cnt, VN[t]);
      bad = 0;
      for (int i = 0; i < VN[t] && i < 128; i++)
        if (fifo_buf[i] != pat(VB[t] + i * step)) bad++;
      check(bad == 0, "R4 element data and order", bad, 0);
      check(first_len == VF[t], "R5 first burst length", first_len, VF[t]);
      v = rd32(PRI + 8);
      check(v[2:0] == 0 && v[13:4] == 0, "R7 final control word", int'(v[13:0]), 0);
      cfg_rd(0, v);
      check(v == 0, "R8 enable cleared", int'(v), 0);
    end

    // R6: mask blocks requests
    clr_mon();
    put_desc(PRI, 'h101, cw(1, 2, 1, 0, 3));
    cfg_wr(8, 32'h80);
    cfg_wr(0, 32'h80);
    req_burst = 1'b1; tick(40);
    check(req_cnt == 0, "R6 masked request ignored", req_cnt, 0);
    cfg_wr(9, 32'h80);
    wait_irq(200, "R6 unmasked transfer completes");
    req_burst = 1'b0;
    check(fifo_cnt == 2, "R6 unmasked count", fifo_cnt, 2);

    // R6/R5/R7: burst-only ignores single; single moves one element
    clr_mon();
    put_desc(PRI, 'h104, cw(1, 5, 2, 0, 3));
    cfg_wr(6, 32'h80);
    cfg_wr(0, 32'h80);
    for (int i = 0; i < 3; i++) begin req_single = 1'b1; tick(1); req_single = 1'b0; tick(8); end
    check(req_cnt == 0, "R6 burst-only ignores single", req_cnt, 0);
    cfg_wr(7, 32'h80);
    req_single = 1'b1; tick(1); req_single = 1'b0;
    tick(30);
    check(fifo_cnt == 1, "R5 single moves one", fifo_cnt, 1);
    v = rd32(PRI + 8);
    check(v[13:4] == 3 && v[2:0] == 1, "R7 partial write-back", int'(v[13:0]), 'h31);
    cfg_rd(0, v);
    check(v == 32'h80, "R8 enable held mid transfer", int'(v), 'h80);
    req_burst = 1'b1;
    wait_irq(300, "R8 interrupt after remainder");
    req_burst = 1'b0;
    check(fifo_cnt == 5 && fifo_buf[4] == pat('h104), "R4 remainder resumes", fifo_cnt, 5);

    // R8: no interrupt when disabled
    clr_mon();
    cfg_wr(11, 32'h80);
    put_desc(PRI, 'h101, cw(1, 2, 1, 0, 3));
    cfg_wr(0, 32'h80);
    req_burst = 1'b1; tick(60); req_burst = 1'b0;
    cfg_rd(0, v);
    check(v == 0 && fifo_cnt == 2, "R8 completes without interrupt enable", fifo_cnt, 2);
    check(!irq_seen, "R8 interrupt suppressed", int'(irq_seen), 0);
    cfg_wr(10, 32'h80);

    // R9: stopped control word
    clr_mon();
    put_desc(PRI, 'h101, cw(0, 2, 1, 0, 3));
    cfg_wr(0, 32'h80);
    req_burst = 1'b1; tick(30); req_burst = 1'b0;
    cfg_rd(0, v);
    check(fifo_cnt == 0 && v == 0, "R9 stopped word moves nothing", fifo_cnt, 0);
    check(!irq_seen, "R9 no interrupt", int'(irq_seen), 0);

    // R3: alternate descriptor
    clr_mon();
    put_desc(PRI, 'h101, cw(0, 2, 1, 0, 3));
    put_desc(ALT, 'h111, cw(1, 2, 1, 0, 3));
    cfg_wr(4, 32'h80);
    cfg_wr(0, 32'h80);
    req_burst = 1'b1;
    wait_irq(200, "R3 alternate completes");
    req_burst = 1'b0;
    check(fifo_cnt == 2 && fifo_buf[0] == pat('h110), "R3 alternate descriptor used",
          int'(fifo_buf[0]), int'(pat('h110)));
    v = rd32(ALT + 8);
    check(v[2:0] == 0, "R7 alternate word stopped", int'(v[2:0]), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule